// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block forms the signed product of two small two's-complement operands one multiplier bit at a time. It uses radix-2 Booth recoding. A controller state machine steps a datapath through a fixed number of iterations. In each iteration it looks at the lowest multiplier bit together with the bit that was shifted out last time. Depending on that pair, it adds the multiplicand into an accumulator, subtracts it, or leaves the accumulator alone. It then shifts accumulator, multiplier and the saved bit right by one place as a single arithmetic shift.

The controller touches the datapath only through five strobes: load, add, subtract, shift and count-down. It observes only three signals: the lowest multiplier bit, the saved bit, and a flag that the iteration counter has reached zero. The accumulator carries one guard bit above the operand width, so the most negative multiplicand can be negated without wrapping.

A user presents both operands and pulses `start` while the block is idle. The block answers with a one-cycle `done` pulse. The product then stays on `product` until the next operation is loaded.

Top module: `booth_mult_top`

## Requirements
- R1: While `rst_n` is low, and after it returns high, `product` reads 0 and `done` reads 0 until an operation completes; a reset in the middle of an operation abandons it.
- R2: For every pair of W-bit signed operands, `product` at the `done` pulse equals their 2W-bit signed product, formed from the upper accumulator bits concatenated with the final multiplier register.
- R3: A multiplicand equal to the most negative W-bit value gives the correct product (for W=4: -8 x 2 = -16, -8 x -8 = +64, -8 x 7 = -56).
- R4: `done` is high for exactly one cycle per operation.
- R5: `product` does not change from the `done` pulse until a new operation is loaded.
- R6: `start` is sampled only while idle; a `start` pulse or operand change during an operation does not alter that operation's result and does not begin another one.
- R7: The add and subtract strobes are never active together, and each is followed in the next cycle by the shift of the same iteration.
- R8: Counting from the cycle in which `start` is presented, `done` arrives after 2W+3 cycles plus one cycle for every iteration whose bit pair is 10 or 01 (the pairs are the multiplier bits i and i-1, with bit -1 taken as 0).
- R9: Exactly W shift steps occur between a load and the following `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled when idle) |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product |

## Verification
The hardest case to reach is the most negative multiplicand combined with a subtract step. Only there does the guard bit of the accumulator matter. A 4-bit path would wrap when it forms minus M and still look plausible for most other operands. The stimulus reaches this case in two ways: it sweeps every operand pair, and it repeats it in directed vectors whose multipliers start with a 10 bit pair. Completion time depends on the recoded bit pattern, so each operation's latency is also checked against a count of its nonzero Booth pairs.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_EVAL  = 3'd2,
    ST_ARITH = 3'd3,
    ST_SHIFT = 3'd4,
    ST_DONE  = 3'd5
  } booth_state_e;
endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_i,
  input  logic           add_i,
  input  logic           sub_i,
  input  logic           shift_i,
  input  logic           dec_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           q0_o,
  output logic           qm1_o,
  output logic           cnt_zero_o,
  output logic [2*W-1:0] product_o
);
  localparam int AW = W + 1;            // accumulator with guard bit
  localparam int CW = $clog2(W + 1);

  logic [AW-1:0] m_q, acc_q, acc_d, sum;
  logic [W-1:0]  q_q, q_d;
  logic          qm1_q, qm1_d;
  logic [CW-1:0] cnt_q;
  logic          acc_en, cnt_en;

  // add/sub unit at accumulator width; carry out of the top bit is dropped
  always_comb begin
    sum = acc_q;
    if (add_i)      sum = acc_q + m_q;
    else if (sub_i) sum = acc_q - m_q;
  end

  always_comb begin
    acc_d = acc_q;
    q_d   = q_q;
    qm1_d = qm1_q;
    if (ld_i) begin
      acc_d = '0;
      q_d   = mplier_i;
      qm1_d = 1'b0;
    end else if (add_i || sub_i) begin
      acc_d = sum;
    end else if (shift_i) begin
      acc_d = {acc_q[AW-1], acc_q[AW-1:1]};
      q_d   = {acc_q[0], q_q[W-1:1]};
      qm1_d = q_q[0];
    end
  end

  assign acc_en = ld_i | add_i | sub_i | shift_i;
  assign cnt_en = ld_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
    end else if (ld_i) begin
      m_q <= {mcand_i[W-1], mcand_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      q_q   <= '0;
      qm1_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      q_q   <= q_d;
      qm1_q <= qm1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_en) begin
      if (ld_i)        cnt_q <= CW'(W);
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign q0_o       = q_q[0];
  assign qm1_o      = qm1_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign product_o  = {acc_q[W-1:0], q_q};
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic q0_i,
  input  logic qm1_i,
  input  logic cnt_zero_i,
  output logic ld_o,
  output logic add_o,
  output logic sub_o,
  output logic shift_o,
  output logic dec_o,
  output logic done_o
);
  booth_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_EVAL;
      ST_EVAL: begin
        if (cnt_zero_i)          state_d = ST_DONE;
        else if (q0_i ^ qm1_i)   state_d = ST_ARITH;
        else                     state_d = ST_SHIFT;
      end
      ST_ARITH: state_d = ST_SHIFT;
      ST_SHIFT: state_d = ST_EVAL;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ld_o    = (state_q == ST_LOAD);
  assign add_o   = (state_q == ST_ARITH) && !q0_i &&  qm1_i;
  assign sub_o   = (state_q == ST_ARITH) &&  q0_i && !qm1_i;
  assign shift_o = (state_q == ST_SHIFT);
  assign dec_o   = (state_q == ST_SHIFT);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/booth_mult_top.sv
module booth_mult_top #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic rst_n_s;
  logic ld_s, add_s, sub_s, shift_s, dec_s;
  logic q0_s, qm1_s, cnt_zero_s;

  booth_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  booth_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start),
    .q0_i       (q0_s),
    .qm1_i      (qm1_s),
    .cnt_zero_i (cnt_zero_s),
    .ld_o       (ld_s),
    .add_o      (add_s),
    .sub_o      (sub_s),
    .shift_o    (shift_s),
    .dec_o      (dec_s),
    .done_o     (done)
  );

  booth_datapath #(.W(W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ld_i       (ld_s),
    .add_i      (add_s),
    .sub_i      (sub_s),
    .shift_i    (shift_s),
    .dec_i      (dec_s),
    .mcand_i    (mcand),
    .mplier_i   (mplier),
    .q0_o       (q0_s),
    .qm1_o      (qm1_s),
    .cnt_zero_o (cnt_zero_s),
    .product_o  (product)
  );
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic           ld,
  input logic           add,
  input logic           sub,
  input logic           shift
);
  localparam int MAXLAT = 3 * W + 2;

  logic [7:0] shifts_q;
  logic [7:0] lat_q;
  logic       busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifts_q <= '0;
      lat_q    <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (ld) begin
        shifts_q <= '0;
        lat_q    <= '0;
        busy_q   <= 1'b1;
      end else begin
        if (shift)  shifts_q <= shifts_q + 1'b1;
        if (busy_q) lat_q    <= lat_q + 1'b1;
        if (done)   busy_q   <= 1'b0;
      end
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(add && sub));

  // R7
  arith_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add || sub) |=> shift);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld || add || sub || shift) |=> $stable(product));

  // R9
  shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_q) |-> (shifts_q == 8'(W)));

  // R8
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (lat_q <= 8'(MAXLAT)));
endmodule

bind booth_mult_top booth_mult_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .product (product),
  .ld      (ld_s),
  .add     (add_s),
  .sub     (sub_s),
  .shift   (shift_s)
);

// File: tb/booth_mult_tb.sv
module booth_mult_top_tb_top;
  localparam int W = 4;
  localparam int NV = 12;
  // {mcand, mplier, expected product}
  localparam logic [15:0] VEC [NV] = '{
    16'h3CF4, 16'h82F0, 16'h8840, 16'h87C8, 16'h78C8, 16'h7731,
    16'hFF01, 16'h0800, 16'h81F8, 16'h18F8, 16'h5DF1, 16'h9931
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  booth_mult_top #(.W(W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .done    (done),
    .product (product)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int arith_steps(input logic [W-1:0] b);
    int n = 0;
    logic prev = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (b[i] != prev) n++;
      prev = b[i];
    end
    return n;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [2*W-1:0] p, output int lat);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    p = product;
  endtask

  initial begin
    logic [2*W-1:0] p;
    int lat;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(product == 0, "R1", int'(product), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(product == 0 && !done, "R1", int'(product), 0);

    // directed table
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][15:12], VEC[v][11:8], p, lat);
      chk(p == VEC[v][7:0], "R3", int'($signed(p)), int'($signed(VEC[v][7:0])));
    end

    // exhaustive sweep with latency
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic signed [2*W-1:0] expp;
        int explat;
        expp = 8'($signed(4'(a)) * $signed(4'(b)));
        explat = 2 * W + 3 + arith_steps(4'(b));
        run_op(4'(a), 4'(b), p, lat);
        chk(p == expp, "R2", int'($signed(p)), int'(expp));
        chk(lat == explat, "R8", lat, explat);
        @(negedge clk);
        // R4: pulse is one cycle; R5: product held
        chk(!done, "R4", int'(done), 0);
        chk(product == expp, "R5", int'($signed(product)), int'(expp));
      end
    end

    // R5: product held while idle for many cycles
    run_op(4'd5, 4'hD, p, lat);
    mcand = 4'h8; mplier = 4'h8;
    repeat (20) @(negedge clk);
    chk(product == 8'hF1, "R5", int'($signed(product)), -15);

    // R6: start and operand changes while busy are ignored
    run_op_busy_poke();

    // R1: reset in the middle of an operation
    @(negedge clk);
    mcand = 4'h7; mplier = 4'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(product == 0, "R1", int'(product), 0);
    chk(!done, "R1", int'(done), 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done) seen++;
      end
      chk(seen == 0 && product == 0, "R1", seen, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run_op_busy_poke();
    int lat = 1;
    int extra = 0;
    @(negedge clk);
    mcand = 4'd3; mplier = 4'hC; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin @(negedge clk); lat++; end
    mcand = 4'h8; mplier = 4'h8; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(product == 8'hF4, "R6", int'($signed(product)), -12);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R6", extra, 0);
    chk(product == 8'hF4, "R6", int'($signed(product)), -12);
  endtask
endmodule